// File: doc/BRIEF.md
# SLIP Response Packet Transmitter

This block turns one bootloader reply into a framed byte stream for a UART transmitter. A requester presents the command code being answered, a 32-bit result word, a pass/fail bit and an error code, and holds them with a valid/ready handshake. The block captures these fields and builds a ten-byte reply. The reply holds a direction marker, the echoed command, a body length of two, the result word and a two-byte body. The body carries the status flag and the most recent error code.

Each reply byte is sent least significant byte first where a field spans several bytes. Before it leaves, each byte is escaped so that the frame delimiter never appears inside the packet. A delimiter byte is sent at the start and at the end of the packet. The downstream sink may hold off any byte with its ready line. The block accepts a new reply only when the previous frame has fully left. The error code reported in the body is remembered from the last failing reply, so a later successful reply still reports it.

Top module: `slip_rsp_tx`

## Requirements
- R1: `req_ready` is high exactly when no frame is in progress. A `req_valid` presented while a frame is being sent is ignored: it produces no extra bytes and does not change the frame in flight.
- R2: Every frame starts and ends with the byte 0xC0, and the first 0xC0 is offered in the cycle after the request is accepted. 0xC0 appears nowhere else in the frame.
- R3: Unescaped packet byte 0 is 0x01, and packet byte 1 is the accepted `req_cmd`.
- R4: Packet bytes 2 and 3 hold the body length 2 least significant byte first, so they are 0x02 then 0x00.
- R5: Packet bytes 4 to 7 hold `req_value`, least significant byte first.
- R6: Packet byte 8 is the status: 0x00 when `req_fail` was 0, and 0x01 when it was 1.
- R7: Packet byte 9 is `req_err` for a failing reply. For a successful reply it is the `req_err` of the most recent failing reply, or 0x00 if none has been sent since reset.
- R8: Inside the frame, a packet byte 0xC0 is sent as 0xDB 0xDC and a packet byte 0xDB is sent as 0xDB 0xDD. All other bytes are sent unchanged.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` keeps its value in the next cycle. This holds between the two halves of an escape pair as well.
- R10: After reset, `tx_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Reply fields are presented |
| req_ready | output | 1 | Block is idle and takes the reply this cycle |
| req_cmd | input | 8 | Command code to echo |
| req_value | input | VAL_W (32) | Result word |
| req_fail | input | 1 | 1 for a failing reply, 0 for success |
| req_err | input | 8 | Error code, stored when `req_fail` is 1 |
| tx_valid | output | 1 | Output byte is valid |
| tx_data | output | 8 | Output byte (framed and escaped) |
| tx_ready | input | 1 | Sink takes the output byte this cycle |

## Verification
A wrong byte index or field selection shows on the next transferred byte as a value out of place in the scoreboard. An off-by-one in the packet length shows as a missing or extra byte before the closing delimiter. A lost escape phase leaves a bare 0xDB followed by an unrelated byte within one transfer. A stale or wrongly cleared error register shows only on the body's last byte, and only in the first successful reply after a failing one, so the stimulus alternates fail and success with distinct codes. A phase that advances under backpressure changes `tx_data` in the very next stalled cycle, so the sink stalls at random, including right after an escape byte.

// File: rtl/slip_rsp_pkg.sv
package slip_rsp_pkg;

    localparam logic [7:0] FRAME_END    = 8'hC0;
    localparam logic [7:0] FRAME_ESC    = 8'hDB;
    localparam logic [7:0] ESC_OF_END   = 8'hDC;
    localparam logic [7:0] ESC_OF_ESC   = 8'hDD;
    localparam logic [7:0] DIR_RESPONSE = 8'h01;

    // Phases of one outgoing frame
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPEN,
        PH_BYTE,
        PH_SUBST,
        PH_CLOSE
    } phase_e;

endpackage

// File: rtl/rsp_byte_mux.sv
// Selects one unescaped reply byte by its position in the packet.
module rsp_byte_mux #(
    parameter int VAL_W    = 32,
    parameter int BODY_LEN = 2,
    parameter int IDX_W    = 4
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       cmd,
    input  logic [VAL_W-1:0] value,
    input  logic             fail,
    input  logic [7:0]       err,
    output logic [7:0]       pkt_byte
);
    import slip_rsp_pkg::*;

    localparam int          VAL_BYTES  = VAL_W / 8;
    localparam int          HDR_LEN    = 4 + VAL_BYTES;
    localparam logic [15:0] SIZE_FIELD = 16'(BODY_LEN);

    always_comb begin
        pkt_byte = 8'h00;
        if (idx == IDX_W'(0)) begin
            pkt_byte = DIR_RESPONSE;
        end else if (idx == IDX_W'(1)) begin
            pkt_byte = cmd;
        end else if (idx == IDX_W'(2)) begin
            pkt_byte = SIZE_FIELD[7:0];
        end else if (idx == IDX_W'(3)) begin
            pkt_byte = SIZE_FIELD[15:8];
        end else if (idx == IDX_W'(HDR_LEN)) begin
            pkt_byte = {7'd0, fail};
        end else if (idx == IDX_W'(HDR_LEN + 1)) begin
            pkt_byte = err;
        end else begin
            for (int k = 0; k < VAL_BYTES; k++) begin
                if (idx == IDX_W'(4 + k)) begin
                    pkt_byte = value[8*k +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/slip_encoder.sv
// Classifies one packet byte for byte stuffing.
module slip_encoder (
    input  logic [7:0] raw,
    output logic       needs_esc,
    output logic [7:0] first_byte,
    output logic [7:0] second_byte
);
    import slip_rsp_pkg::*;

    always_comb begin
        needs_esc   = 1'b0;
        first_byte  = raw;
        second_byte = ESC_OF_END;
        if (raw == FRAME_END) begin
            needs_esc   = 1'b1;
            first_byte  = FRAME_ESC;
            second_byte = ESC_OF_END;
        end else if (raw == FRAME_ESC) begin
            needs_esc   = 1'b1;
            first_byte  = FRAME_ESC;
            second_byte = ESC_OF_ESC;
        end
    end

endmodule

// File: rtl/err_keeper.sv
// Holds the error code of the most recent failing reply.
module err_keeper #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [ERR_W-1:0] err_in,
    output logic [ERR_W-1:0] stored
);
    logic [ERR_W-1:0] err_d, err_q;

    always_comb begin
        err_d = err_q;
        if (capture) begin
            err_d = err_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= err_d;
        end
    end

    assign stored = err_q;

endmodule

// File: rtl/slip_rsp_tx.sv
module slip_rsp_tx #(
    parameter int VAL_W    = 32,
    parameter int BODY_LEN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [7:0]       req_cmd,
    input  logic [VAL_W-1:0] req_value,
    input  logic             req_fail,
    input  logic [7:0]       req_err,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    input  logic             tx_ready
);
    import slip_rsp_pkg::*;

    localparam int PKT_LEN  = 4 + VAL_W / 8 + BODY_LEN;
    localparam int IDX_W    = $clog2(PKT_LEN + 1);
    localparam int LAST_IDX = PKT_LEN - 1;

    typedef struct packed {
        phase_e           ph;
        logic [IDX_W-1:0] idx;
        logic [7:0]       cmd;
        logic [VAL_W-1:0] value;
        logic             fail;
        logic [7:0]       err;
    } tx_state_t;

    tx_state_t  s_d, s_q;
    logic [7:0] raw_byte;
    logic       needs_esc;
    logic [7:0] esc_first;
    logic [7:0] esc_second;
    logic       err_capture;
    logic [7:0] err_stored;

    rsp_byte_mux #(
        .VAL_W   (VAL_W),
        .BODY_LEN(BODY_LEN),
        .IDX_W   (IDX_W)
    ) i_mux (
        .idx     (s_q.idx),
        .cmd     (s_q.cmd),
        .value   (s_q.value),
        .fail    (s_q.fail),
        .err     (s_q.err),
        .pkt_byte(raw_byte)
    );

    slip_encoder i_enc (
        .raw        (raw_byte),
        .needs_esc  (needs_esc),
        .first_byte (esc_first),
        .second_byte(esc_second)
    );

    err_keeper #(
        .ERR_W(8)
    ) i_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(err_capture),
        .err_in (req_err),
        .stored (err_stored)
    );

    always_comb begin
        s_d         = s_q;
        req_ready   = 1'b0;
        tx_valid    = 1'b0;
        tx_data     = FRAME_END;
        err_capture = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    s_d.ph      = PH_OPEN;
                    s_d.idx     = '0;
                    s_d.cmd     = req_cmd;
                    s_d.value   = req_value;
                    s_d.fail    = req_fail;
                    s_d.err     = req_fail ? req_err : err_stored;
                    err_capture = req_fail;
                end
            end
            PH_OPEN: begin
                tx_valid = 1'b1;
                tx_data  = FRAME_END;
                if (tx_ready) begin
                    s_d.ph = PH_BYTE;
                end
            end
            PH_BYTE: begin
                tx_valid = 1'b1;
                tx_data  = esc_first;
                if (tx_ready) begin
                    if (needs_esc) begin
                        s_d.ph = PH_SUBST;
                    end else if (s_q.idx == IDX_W'(LAST_IDX)) begin
                        s_d.ph = PH_CLOSE;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            PH_SUBST: begin
                tx_valid = 1'b1;
                tx_data  = esc_second;
                if (tx_ready) begin
                    if (s_q.idx == IDX_W'(LAST_IDX)) begin
                        s_d.ph = PH_CLOSE;
                    end else begin
                        s_d.ph  = PH_BYTE;
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            PH_CLOSE: begin
                tx_valid = 1'b1;
                tx_data  = FRAME_END;
                if (tx_ready) begin
                    s_d.ph = PH_IDLE;
                end
            end
            default: begin
                s_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, idx: '0, cmd: '0, value: '0, fail: 1'b0, err: '0};
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/slip_rsp_tx_chk.sv
module slip_rsp_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       tx_valid,
    input logic [7:0] tx_data,
    input logic       tx_ready
);
    import slip_rsp_pkg::*;

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R9

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !tx_valid); // R1

    AST_OPEN_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> tx_valid && tx_data == FRAME_END); // R2

    AST_ESC_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && tx_data == FRAME_ESC |=>
        tx_valid && (tx_data == ESC_OF_END || tx_data == ESC_OF_ESC)); // R8

endmodule

bind slip_rsp_tx slip_rsp_tx_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready)
);

// File: tb/test_slip_rsp_tx.sv
module test_slip_rsp_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_cmd = 8'h00;
    logic [31:0] req_value = 32'h0;
    logic        req_fail = 1'b0;
    logic [7:0]  req_err = 8'h00;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready;

    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;
    int          ready_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0]  model_err = 8'h00;
    logic        stalled = 1'b0;
    logic [7:0]  stalled_data = 8'h00;
    logic        done = 1'b0;

    logic [7:0]  exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    slip_rsp_tx i_slip_rsp_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .req_cmd  (req_cmd),
        .req_value(req_value),
        .req_fail (req_fail),
        .req_err  (req_err),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Expected byte after byte stuffing (R8)
    function automatic void push_pkt(input logic [7:0] b, input string tag);
        if (b == 8'hC0) begin
            exp_q.push_back(8'hDB); tag_q.push_back("R8");
            exp_q.push_back(8'hDC); tag_q.push_back("R8");
        end else if (b == 8'hDB) begin
            exp_q.push_back(8'hDB); tag_q.push_back("R8");
            exp_q.push_back(8'hDD); tag_q.push_back("R8");
        end else begin
            exp_q.push_back(b); tag_q.push_back(tag);
        end
    endfunction

    // Driver: accepts one reply and pushes its expected frame
    task automatic send(input logic [7:0] cmd, input logic [31:0] val,
                        input logic fail, input logic [7:0] err, input bit poke_busy);
        logic [7:0] body_err;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_cmd = cmd; req_value = val; req_fail = fail; req_err = err;
        req_valid = 1'b1;
        body_err = fail ? err : model_err;
        if (fail) model_err = err;
        exp_q.push_back(8'hC0); tag_q.push_back("R2");
        push_pkt(8'h01, "R3");
        push_pkt(cmd, "R3");
        push_pkt(8'h02, "R4");
        push_pkt(8'h00, "R4");
        for (int k = 0; k < 4; k++) push_pkt(val[8*k +: 8], "R5");
        push_pkt({7'd0, fail}, "R6");
        push_pkt(body_err, "R7");
        exp_q.push_back(8'hC0); tag_q.push_back("R2");
        @(negedge clk);
        if (poke_busy) begin
            // R1: requests while busy must be ignored
            req_cmd = 8'hC0; req_value = 32'hDEADBEEF; req_fail = 1'b1; req_err = 8'h77;
            for (int k = 0; k < 5; k++) begin
                check(req_ready == 1'b0, "R1 ready while busy", req_ready, 0);
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
    endtask

    // Monitor / scoreboard and sink
    always @(negedge clk) begin
        cycles++;
        if (cycles > 60000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (!rst_n) begin
            tx_ready = 1'b0;
            stalled  = 1'b0;
        end else begin
            if (stalled) begin
                check(tx_valid === 1'b1 && tx_data === stalled_data, "R9 hold under stall",
                      {23'd0, tx_valid, tx_data}, {24'd1, stalled_data});
            end
            case (ready_mode)
                0: tx_ready = 1'b1;
                1: tx_ready = lfsr[0] | lfsr[3];
                default: tx_ready = lfsr[0];
            endcase
            if (tx_valid === 1'b1 && tx_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected byte", tx_data, 0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(tx_data === e, t, tx_data, e);
                end
            end
            stalled      = (tx_valid === 1'b1) && !tx_ready;
            stalled_data = tx_data;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(tx_valid === 1'b0, "R10 tx_valid in reset", tx_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_valid === 1'b0, "R10 tx_valid after reset", tx_valid, 0);
        check(req_ready === 1'b1, "R10 req_ready after reset", req_ready, 1);

        // Plain success, stored error still zero (R7)
        send(8'h0A, 32'h12345678, 1'b0, 8'h55, 1'b0);
        // Failure with bytes needing escape everywhere (R8)
        send(8'hC0, 32'hC0DB00C0, 1'b1, 8'hDB, 1'b1);
        // Success reports the stored error 0xDB (R7)
        send(8'hDB, 32'h00000000, 1'b0, 8'h11, 1'b0);
        ready_mode = 1;
        send(8'h09, 32'hDBDBC0C0, 1'b1, 8'hC0, 1'b1);
        send(8'h02, 32'hFFFFFFFF, 1'b0, 8'h00, 1'b0);
        ready_mode = 2;
        for (int n = 0; n < 24; n++) begin
            logic [31:0] r;
            logic [7:0]  c;
            r = $urandom;
            c = (n % 3 == 0) ? 8'hC0 : 8'($urandom);
            if (n % 4 == 1) r[15:8] = 8'hDB;
            send(c, r, 1'(n % 3 == 1), 8'($urandom), 1'(n % 5 == 0));
            if (n == 12) ready_mode = 1;
        end

        while (exp_q.size() != 0) @(negedge clk);
        // R1: no spurious frame once idle
        repeat (20) @(negedge clk);
        check(tx_valid === 1'b0, "R1 idle after last frame", tx_valid, 0);
        check(req_ready === 1'b1, "R1 ready when idle", req_ready, 1);
        done = 1'b1;
        finish_run();
    end

endmodule